// File: doc/BRIEF.md
# Vector gather line-grouping sequencer

This block collects four 32-bit elements from memory for one vector gather. A request carries a 64-bit base address and four unsigned 32-bit byte offsets. Lane i reads the four bytes starting at base plus offset i, with the sum taken modulo 2^64. The four elements are packed into one 128-bit result. Lane i sits in bits [32i+31:32i], and each element is little-endian: the byte at the lowest address is the least significant.

The block reads memory through a single port that returns one 64-byte line per access. It groups the lanes by line and fetches one line per access. On each access it fills every still-open lane whose bytes lie in the returned line. A gather whose four elements share one line therefore needs a single access. An element that runs past the end of a line is built from two consecutive line accesses. When a final response arrives with zero latency, the block can take the next request in that same cycle. This sustains one gather per cycle for same-line requests.

Top module: `vgather_seq`

## Requirements
- R1: The result holds lane i in bits [32i+31:32i]. Byte j of lane i (bits [32i+8j+7:32i+8j]) is the memory byte at base + offset i + j. Offsets are unsigned, and the address sum wraps modulo 2^64.
- R2: After reset, req_ready is 1, mem_req is 0 and res_valid is 0.
- R3: Each line access drives mem_addr with bits [5:0] equal to zero. Bits [63:6] of mem_addr give the line number. mem_req and mem_addr hold steady until mem_resp_valid is seen with mem_req high.
- R4: A gather whose four elements lie inside one line uses exactly one line access. When the final response for a gather arrives, req_ready is 1 in that same cycle. With a zero-latency memory this allows one same-line gather to be accepted, and one result to be returned, every cycle.
- R5: Each access fetches the line that the lowest-numbered unfilled lane still needs. Every unfilled lane needing that line is filled from the same response. The number of accesses per gather follows this rule.
- R6: An element starts at in-line byte position p, the low 6 address bits. If p is greater than 60, the element straddles two lines. Its bytes below the line end come from that line. Its remaining bytes come from the next line, whose number is one higher modulo 2^58.
- R7: res_valid is high for one cycle per gather. That cycle is the one right after the response that fills the last lane. res_data is valid during that cycle.
- R8: While a gather is waiting for a response that will not complete it, req_ready is 0. A request held on the inputs during that time is not taken until the current gather is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Block takes the request this cycle if req_valid is high |
| req_base | input | 64 | Base byte address |
| req_offs | input | 128 | Four unsigned byte offsets; lane i in bits [32i+31:32i] |
| mem_req | output | 1 | Line read requested |
| mem_addr | output | 64 | Line-aligned byte address of the line requested |
| mem_resp_valid | input | 1 | Line data present for the current request |
| mem_resp_line | input | 512 | Returned line; byte k in bits [8k+7:8k] |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 128 | Packed gathered elements |

## Verification
Some internal faults only change which lines the block fetches. Examples are a lane left marked open, a wrong line number held for a lane, or a straddling lane that never advances to its next line. Such faults show up at the memory port in the same gather. The bench sees an access count, or a first line address, that differs from the grouping rule before the gather's result strobe. A wrong byte select or a wrong straddle split shows in res_data in the cycle right after the final response. A lost completion shows as a missing strobe and a scoreboard left with entries at the end of the run.

// File: rtl/vgather_pkg.sv
package vgather_pkg;
  localparam int unsigned VG_ADDR_W     = 64;
  localparam int unsigned VG_OFF_W      = 32;
  localparam int unsigned VG_LANES      = 4;
  localparam int unsigned VG_ELEM_BYTES = 4;
  localparam int unsigned VG_LINE_BYTES = 64;
endpackage

// File: rtl/vgather_lane.sv
module vgather_lane #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned OFF_W      = 32,
  parameter int unsigned ELEM_BYTES = 4,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned LN_W      = ADDR_W - OFS_W,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned ELEM_W    = ELEM_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic              resp,
  input  logic [LN_W-1:0]   cur_line,
  input  logic [LINE_W-1:0] line,
  output logic              pend,
  output logic [LN_W-1:0]   need,
  output logic              hit,
  output logic              fin,
  output logic [ELEM_W-1:0] elem
);
  logic [ADDR_W-1:0] ea;
  logic              pend_q, pend_d;
  logic              hi_q, hi_d;
  logic [LN_W-1:0]   need_q, need_d;
  logic [OFS_W-1:0]  bo_q, bo_d;
  logic [ELEM_W-1:0] elem_q, elem_d;
  logic              strad;

  assign ea    = base + ADDR_W'(off);
  assign strad = bo_q > OFS_W'(LINE_BYTES - ELEM_BYTES);
  assign hit   = resp & pend_q & (need_q == cur_line);
  assign fin   = hit & (hi_q | ~strad);
  assign pend  = pend_q;
  assign need  = need_q;
  assign elem  = elem_q;

  always_comb begin
    pend_d = pend_q;
    hi_d   = hi_q;
    need_d = need_q;
    bo_d   = bo_q;
    if (load) begin
      pend_d = 1'b1;
      hi_d   = 1'b0;
      need_d = ea[ADDR_W-1:OFS_W];
      bo_d   = ea[OFS_W-1:0];
    end else if (hit) begin
      if (fin) begin
        pend_d = 1'b0;
      end else begin
        hi_d   = 1'b1;
        need_d = need_q + LN_W'(1);
      end
    end
  end

  // byte j lands in the first line unless its position wraps past the end
  always_comb begin
    elem_d = elem_q;
    for (int j = 0; j < int'(ELEM_BYTES); j++) begin
      logic [OFS_W:0]   pos;
      logic [OFS_W-1:0] idx;
      pos = {1'b0, bo_q} + (OFS_W+1)'(j);
      idx = pos[OFS_W-1:0];
      if (hit && (pos[OFS_W] == hi_q))
        elem_d[8*j +: 8] = line[{idx, 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hi_q   <= hi_d;
    end
  end

  always_ff @(posedge clk) begin
    need_q <= need_d;
    bo_q   <= bo_d;
    elem_q <= elem_d;
  end

  // R6: the second-line phase exists only for a straddling element
  p_hi_needs_straddle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hi_q) |-> strad);
endmodule

// File: rtl/vgather_pick.sv
module vgather_pick #(
  parameter int unsigned LANES = 4,
  parameter int unsigned LN_W  = 58
) (
  input  logic [LANES-1:0]           pend,
  input  logic [LANES-1:0][LN_W-1:0] need,
  output logic [LN_W-1:0]            cur_line
);
  // lowest-numbered open lane wins
  always_comb begin
    cur_line = need[0];
    for (int i = int'(LANES) - 1; i >= 0; i--) begin
      if (pend[i]) cur_line = need[i];
    end
  end
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq
  import vgather_pkg::*;
#(
  parameter int unsigned ADDR_W     = VG_ADDR_W,
  parameter int unsigned OFF_W      = VG_OFF_W,
  parameter int unsigned LANES      = VG_LANES,
  parameter int unsigned ELEM_BYTES = VG_ELEM_BYTES,
  parameter int unsigned LINE_BYTES = VG_LINE_BYTES,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned LN_W      = ADDR_W - OFS_W,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned ELEM_W    = ELEM_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_base,
  input  logic [LANES*OFF_W-1:0]  req_offs,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_resp_valid,
  input  logic [LINE_W-1:0]       mem_resp_line,
  output logic                    res_valid,
  output logic [LANES*ELEM_W-1:0] res_data
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                      busy_q, busy_d;
  logic                      rv_q, rv_d;
  logic                      resp, finish, accept;
  logic [LANES-1:0]          pend, hit, fin;
  logic [LANES-1:0][LN_W-1:0] need;
  logic [LN_W-1:0]           cur_line;

  assign resp      = busy_q & mem_resp_valid;
  assign finish    = resp & ((pend & ~fin) == '0);
  assign req_ready = ~busy_q | finish;
  assign accept    = req_valid & req_ready;
  assign mem_req   = busy_q;
  assign mem_addr  = {cur_line, {OFS_W{1'b0}}};
  assign res_valid = rv_q;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    vgather_lane #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W),
      .ELEM_BYTES(ELEM_BYTES), .LINE_BYTES(LINE_BYTES)
    ) lane_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (accept),
      .base     (req_base),
      .off      (req_offs[g*OFF_W +: OFF_W]),
      .resp     (resp),
      .cur_line (cur_line),
      .line     (mem_resp_line),
      .pend     (pend[g]),
      .need     (need[g]),
      .hit      (hit[g]),
      .fin      (fin[g]),
      .elem     (res_data[g*ELEM_W +: ELEM_W])
    );
  end

  vgather_pick #(.LANES(LANES), .LN_W(LN_W)) pick_i (
    .pend     (pend),
    .need     (need),
    .cur_line (cur_line)
  );

  always_comb begin
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    rv_d = finish;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rv_q   <= rv_d;
    end
  end

  // R3: an unanswered access keeps its request and line address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_resp_valid) |=> (mem_req && $stable(mem_addr)));

  // R5: the chosen line always serves at least one open lane
  p_hit_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_q && mem_resp_valid) |-> (hit != '0));

  // R7: a result strobe follows a response in the previous cycle
  p_valid_after_resp_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |-> $past(mem_req && mem_resp_valid));

  // R8: no new request while an access waits
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_resp_valid) |-> !req_ready);
endmodule

// File: tb/vgather_seq_tb_top.sv
module vgather_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [63:0]  req_base = '0;
  logic [127:0] req_offs = '0;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic         mem_resp_valid;
  logic [511:0] mem_resp_line;
  logic         res_valid;
  logic [127:0] res_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vgather_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offs(req_offs),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line),
    .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: each byte a function of its address
  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ a[63:56] ^ 8'h5A;
  endfunction

  logic [3:0] lat = 4'd0;
  logic [3:0] wcnt;

  always_comb begin
    for (int j = 0; j < 64; j++)
      mem_resp_line[8*j +: 8] = mbyte({mem_addr[63:6], 6'b0} + 64'(j));
  end
  assign mem_resp_valid = mem_req && (wcnt >= lat);

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_resp_valid) wcnt <= wcnt + 4'd1;
    else                            wcnt <= 4'd0;
  end

  typedef struct {
    logic [127:0] d;
    int           lines;
    logic [63:0]  first;
    bit           back;
    string        tag;
  } item_t;
  item_t sb[$];

  // expected lines from the grouping rule
  task automatic model(input logic [63:0] b, input logic [127:0] o, output int n,
                       output logic [63:0] first);
    logic [57:0] nd [4];
    bit pd [4];
    bit hi [4];
    bit st [4];
    logic [57:0] cur;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] a;
      a = b + {32'b0, o[32*i +: 32]};
      nd[i] = a[63:6]; pd[i] = 1; hi[i] = 0; st[i] = (a[5:0] > 6'd60);
    end
    n = 0; first = '0;
    while (pd[0] || pd[1] || pd[2] || pd[3]) begin
      cur = '0;
      for (int i = 3; i >= 0; i--) if (pd[i]) cur = nd[i];
      if (n == 0) first = {cur, 6'b0};
      n++;
      for (int i = 0; i < 4; i++) begin
        if (pd[i] && nd[i] == cur) begin
          if (st[i] && !hi[i]) begin hi[i] = 1; nd[i] = nd[i] + 58'd1; end
          else pd[i] = 0;
        end
      end
    end
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [63:0] b, input logic [31:0] o0, input logic [31:0] o1,
                      input logic [31:0] o2, input logic [31:0] o3,
                      input bit back, input string tag);
    item_t it;
    logic [127:0] o;
    o = {o3, o2, o1, o0};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        it.d[32*i + 8*j +: 8] = mbyte(b + {32'b0, o[32*i +: 32]} + 64'(j));
    model(b, o, it.lines, it.first);
    it.back = back;
    it.tag  = tag;
    req_valid = 1'b1; req_base = b; req_offs = o;
    while (!req_ready) @(negedge clk);
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  int acc_cnt = 0;
  logic [63:0] acc_first = '0;
  int last_res = -10;
  bit misalign = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check("R7 unexpected strobe", 128'(1), 128'(0));
        end else begin
          item_t it;
          it = sb.pop_front();
          check({it.tag, " R1 data"}, res_data, it.d);
          check({it.tag, " R5 line count"}, 128'(acc_cnt), 128'(it.lines));
          check({it.tag, " R5 first line"}, 128'(acc_first), 128'(it.first));
          if (it.back) check({it.tag, " R4 back-to-back"}, 128'(cyc), 128'(last_res + 1));
        end
        last_res = cyc;
        acc_cnt = 0;
      end
      if (mem_req && mem_resp_valid) begin
        if (acc_cnt == 0) acc_first = mem_addr;
        if (mem_addr[5:0] != 6'd0) misalign = 1;
        acc_cnt++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 req_ready", 128'(req_ready), 128'(1));
    check("R2 mem_req", 128'(mem_req), 128'(0));
    check("R2 res_valid", 128'(res_valid), 128'(0));

    // R4: one line, last lane at position 60 (no straddle)
    send(64'h1000, 32'd0, 32'd4, 32'd8, 32'd60, 0, "R4 one line");
    idle();
    // R5: four distinct lines, one far away
    send(64'h2000, 32'h0, 32'h100, 32'h40, 32'h0030_0000, 0, "R5 four lines");
    idle();
    // R5: lanes 0,2 and 1,3 share lines
    send(64'h3010, 32'h0, 32'h80, 32'h8, 32'h84, 0, "R5 paired");
    idle();
    // R6: lane 0 straddles, others in next line
    send(64'h203E, 32'd0, 32'd4, 32'd8, 32'd12, 0, "R6 straddle lane0");
    idle();
    // R6: position 63
    send(64'h3F, 32'd0, 32'd4, 32'd8, 32'd12, 0, "R6 pos63");
    idle();
    // R6: position 61, lane 2 straddles, lane 0 elsewhere
    send(64'h5000, 32'h400, 32'h0, 32'h3D, 32'h44, 0, "R6 pos61 lane2");
    idle();
    // R1/R6: wrap at top of address space
    send(64'hFFFF_FFFF_FFFF_FFFE, 32'h0, 32'h2, 32'h40, 32'h80, 0, "R6 wrap");
    idle();
    send(64'hFFFF_FFFF_FFFF_FFF0, 32'hFFFF_FFFF, 32'h10, 32'h8000_0000, 32'h4, 0, "R1 large offs");
    idle();

    // R8: latency, request held while busy
    lat = 4'd3;
    send(64'h7000, 32'h0, 32'h40, 32'h80, 32'hC0, 0, "R8 slow first");
    check("R8 ready low while waiting", 128'(req_ready), 128'(0));
    check("R3 mem_req held", 128'(mem_req), 128'(1));
    send(64'h7100, 32'h3, 32'h7, 32'h2, 32'h1, 0, "R8 held second");
    idle();
    repeat (30) @(negedge clk);

    // R4: back-to-back same-line gathers with zero latency
    lat = 4'd0;
    send(64'h9000, 32'd0, 32'd4, 32'd8, 32'd12, 0, "R4 burst a");
    send(64'h9040, 32'd12, 32'd8, 32'd4, 32'd0, 1, "R4 burst b");
    send(64'h9080, 32'd20, 32'd20, 32'd20, 32'd20, 1, "R4 burst c");
    send(64'h90C0, 32'd60, 32'd0, 32'd30, 32'd1, 1, "R4 burst d");
    idle();

    for (int k = 0; k < 100 && sb.size() != 0; k++) @(negedge clk);
    check("R7 all results returned", 128'(sb.size()), 128'(0));
    check("R3 aligned addresses", 128'(misalign), 128'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule